// File: doc/BRIEF.md
# Offset-Coded Instruction Address Bus Link

This block carries instruction addresses across a wide, heavily loaded bus and lowers the number of wires that toggle. An encoder and a matching decoder are joined by the bus plus one extra flag wire. For each address, the encoder computes the difference from the previous address. If that difference is one of a small fixed set of common steps, the encoder does not send the address. It sends the previous bus word XORed with a word of weight zero or one, and it raises the flag. For any other difference it sends the address itself and lowers the flag. The decoder undoes this: it XORs the new bus word with the one it saw before, turns the resulting low-weight word back into a step, and adds the step to the address it decoded last.

The fixed table has one entry of weight zero and one entry per bus bit. A step of +1 gives the all-zero word, so straight-line fetch leaves the bus quiet. Steps +2 up to +(W/2+1) each toggle one bit in the lower half of the bus. Steps -1 down to -(W/2) each toggle one bit in the upper half. All address arithmetic wraps modulo 2^W.

Addresses enter on a valid/ready stream. The decoded addresses leave on a valid/ready stream. The encoder and decoder stages move together. When the decoded output is valid and not accepted, both stages hold and the input ready goes low. When a cycle carries no transfer, the bus word does not change.

Top module: `addr_offset_link`

## Requirements
- R1: After reset, bus_data is zero, bus_flag is 0, bus_valid is 0 and dec_valid is 0.
- R2: The first address accepted after reset is always sent raw: bus_data equals that address and bus_flag is 0, whatever the address.
- R3: For an accepted address equal to the previous accepted address plus 1, bus_data is unchanged from its prior value and bus_flag is 1.
- R4: For a step d with 2 <= d <= W/2+1, bus_data becomes its prior value with only bit d-2 inverted, and bus_flag is 1.
- R5: For a step d with -W/2 <= d <= -1, bus_data becomes its prior value with only bit W/2-1-d inverted, and bus_flag is 1. With W=32, -1 inverts bit 16 and -16 inverts bit 31.
- R6: Any other step sends the raw address on bus_data with bus_flag 0. This includes 0, +W/2+2 and -(W/2+1).
- R7: Steps are taken modulo 2^W, so 0 following all-ones is a step of +1.
- R8: The cycle after an address is placed on the bus, dec_valid is 1 and dec_addr equals that address.
- R9: While dec_valid is 1 and dec_ready is 0, in_ready is 0, and bus_data, bus_flag, dec_valid and dec_addr all hold their values.
- R10: A cycle with no accepted input leaves bus_data and bus_flag unchanged, and bus_valid is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source address is present |
| in_ready | output | 1 | Link can take an address this cycle |
| in_addr | input | W | Source address |
| bus_data | output | W | Encoded bus word |
| bus_flag | output | 1 | 1 when bus_data carries a coded step, 0 when it carries a raw address |
| bus_valid | output | 1 | bus_data was updated by a transfer in the last cycle |
| dec_ready | input | 1 | Consumer accepts the decoded address |
| dec_valid | output | 1 | Decoded address is present |
| dec_addr | output | W | Decoded address |

## Verification
On every cycle, the assertions check these behaviours:
- A +1 step keeps the bus word unchanged.
- The first transfer after reset is raw.
- Idle cycles leave the bus word unchanged.
- A stall freezes both stages.
- A coded bus word XORed with the previous one always has weight zero or one.

Other behaviours can only be shown by the bench scenarios:
- Each step maps to the exact bit required.
- Steps just outside the table fall back to raw addresses.
- Steps wrap correctly near zero and near the sign boundary.
- The decoded address matches the source address across full sweeps of steps from several bases.

// File: rtl/addr_offset_pkg.sv
package addr_offset_pkg;
  // How a bus word is to be read by the decoder
  typedef enum logic {
    XFER_RAW   = 1'b0,
    XFER_CODED = 1'b1
  } xfer_kind_e;
endpackage

// File: rtl/step_to_code.sv
module step_to_code #(
  parameter int W = 32
) (
  input  logic [W-1:0] step,
  output logic         hit,
  output logic [W-1:0] code
);
  localparam int HALF = W / 2;

  logic zero_hit;
  assign zero_hit = (step == W'(1));

  for (genvar i = 0; i < HALF; i++) begin : g_lanes
    assign code[i]        = (step == W'(i + 2));
    assign code[HALF + i] = (step == W'(-(i + 1)));
  end

  assign hit = zero_hit | (|code);
endmodule

// File: rtl/code_to_step.sv
module code_to_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] code,
  output logic         legal,
  output logic [W-1:0] step
);
  localparam int HALF = W / 2;

  always_comb begin
    legal = 1'b0;
    step  = '0;
    if (code == '0) begin
      legal = 1'b1;
      step  = W'(1);
    end
    for (int i = 0; i < W; i++) begin
      if (code == (W'(1) << i)) begin
        legal = 1'b1;
        step  = (i < HALF) ? W'(i + 2) : W'(-(i - HALF + 1));
      end
    end
  end
endmodule

// File: rtl/offset_encoder.sv
module offset_encoder
  import addr_offset_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         take,
  input  logic [W-1:0] addr,
  output logic [W-1:0] bus_q,
  output xfer_kind_e   kind_q,
  output logic         bus_vld_q
);
  logic [W-1:0] prev_addr;
  logic         primed;
  logic [W-1:0] step;
  logic         hit;
  logic [W-1:0] code;

  assign step = addr - prev_addr;

  step_to_code #(.W(W)) u_book (
    .step(step),
    .hit (hit),
    .code(code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      primed    <= 1'b0;
      bus_q     <= '0;
      kind_q    <= XFER_RAW;
      bus_vld_q <= 1'b0;
    end else if (adv) begin
      bus_vld_q <= take;
      if (take) begin
        prev_addr <= addr;
        primed    <= 1'b1;
        if (hit && primed) begin
          bus_q  <= bus_q ^ code;
          kind_q <= XFER_CODED;
        end else begin
          bus_q  <= addr;
          kind_q <= XFER_RAW;
        end
      end
    end
  end

  // R3
  seq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && take && primed && addr == prev_addr + W'(1)) |=>
      (bus_q == $past(bus_q) && kind_q == XFER_CODED));

  // R2
  first_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && take && !primed) |=> (bus_q == $past(addr) && kind_q == XFER_RAW));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(adv && take)) |=> ($stable(bus_q) && $stable(kind_q)));
endmodule

// File: rtl/offset_decoder.sv
module offset_decoder
  import addr_offset_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         bus_vld,
  input  logic [W-1:0] bus,
  input  xfer_kind_e   kind,
  output logic         out_vld_q,
  output logic [W-1:0] out_addr_q
);
  logic [W-1:0] prev_bus;
  logic         legal;
  logic [W-1:0] step;

  code_to_step #(.W(W)) u_rbook (
    .code (bus ^ prev_bus),
    .legal(legal),
    .step (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_bus   <= '0;
      out_addr_q <= '0;
      out_vld_q  <= 1'b0;
    end else if (adv) begin
      out_vld_q <= bus_vld;
      if (bus_vld) begin
        prev_bus   <= bus;
        out_addr_q <= (kind == XFER_CODED) ? out_addr_q + step : bus;
      end
    end
  end

  // R4 R5: a coded word differs from the last one in at most one bit
  coded_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && kind == XFER_CODED) |-> ($countones(bus ^ prev_bus) <= 1 && legal));
endmodule

// File: rtl/addr_offset_link.sv
module addr_offset_link
  import addr_offset_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_addr,
  output logic [W-1:0] bus_data,
  output logic         bus_flag,
  output logic         bus_valid,
  input  logic         dec_ready,
  output logic         dec_valid,
  output logic [W-1:0] dec_addr
);
  logic       adv;
  xfer_kind_e kind;

  assign adv      = !(dec_valid && !dec_ready);
  assign in_ready = adv;
  assign bus_flag = (kind == XFER_CODED);

  offset_encoder #(.W(W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .take     (in_valid),
    .addr     (in_addr),
    .bus_q    (bus_data),
    .kind_q   (kind),
    .bus_vld_q(bus_valid)
  );

  offset_decoder #(.W(W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .bus_vld   (bus_valid),
    .bus       (bus_data),
    .kind      (kind),
    .out_vld_q (dec_valid),
    .out_addr_q(dec_addr)
  );

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=>
      ($stable(dec_addr) && dec_valid && $stable(bus_data) && $stable(bus_flag)));
endmodule

// File: tb/addr_offset_link_test.sv
module addr_offset_link_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_addr = '0;
  logic [W-1:0] bus_data;
  logic         bus_flag;
  logic         bus_valid;
  logic         dec_ready = 1'b1;
  logic         dec_valid;
  logic [W-1:0] dec_addr;

  int checks = 0;
  int fails = 0;
  int coded_toggles = 0;
  int raw_toggles = 0;

  logic [W-1:0] m_bus = '0;
  logic [W-1:0] m_prev = '0;
  logic         m_primed = 1'b0;

  always #2.5 clk = ~clk;

  addr_offset_link #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .bus_data(bus_data), .bus_flag(bus_flag),
    .bus_valid(bus_valid), .dec_ready(dec_ready), .dec_valid(dec_valid),
    .dec_addr(dec_addr)
  );

  task automatic chk(input logic ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("toggles coded=%0d raw=%0d", coded_toggles, raw_toggles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Expected bus word and flag for a new address, from the requirements
  task automatic predict(input logic [W-1:0] a, output logic [W-1:0] eb, output logic ef);
    int d;
    d = int'(a - m_prev);
    ef = 1'b1;
    if (!m_primed)                 begin eb = a; ef = 1'b0; end
    else if (d == 1)               eb = m_bus;
    else if (d >= 2 && d <= W/2+1) eb = m_bus ^ (W'(1) << (d - 2));
    else if (d <= -1 && d >= -W/2) eb = m_bus ^ (W'(1) << (W/2 - 1 - d));
    else                           begin eb = a; ef = 1'b0; end
  endtask

  task automatic send(input logic [W-1:0] a, input string req);
    logic [W-1:0] eb;
    logic ef;
    predict(a, eb, ef);
    raw_toggles += $countones(a ^ m_prev);
    coded_toggles += $countones(eb ^ m_bus);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr = a;
    @(posedge clk); #1;
    chk(bus_data == eb && bus_flag == ef && bus_valid, req,
        {bus_flag, bus_data}, {ef, eb});
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    // R8
    chk(dec_valid && dec_addr == a, "R8", {dec_valid, dec_addr}, {1'b1, a});
    m_bus = eb; m_prev = a; m_primed = 1'b1;
  endtask

  function automatic string req_of(input int d);
    if (d == 1) return "R3";
    if (d >= 2 && d <= W/2+1) return "R4";
    if (d <= -1 && d >= -W/2) return "R5";
    return "R6";
  endfunction

  initial begin
    int n = 0;
    while (n < 100000) begin @(posedge clk); n++; end
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    logic [W-1:0] hold_bus;
    logic [W-1:0] hold_dec;
    logic hold_flag;
    logic [W-1:0] bases [3];
    bases[0] = 32'h0000_1000;
    bases[1] = 32'h7FFF_FFF0;
    bases[2] = 32'hFFFF_FFF8;

    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(bus_data == '0 && !bus_flag && !bus_valid && !dec_valid, "R1",
        {bus_flag, bus_data}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R2: first transfer raw even if it would look like +1 from zero
    send(32'h0000_0001, "R2");
    send(32'h0000_0002, "R3");

    // R4 R5 R6 sweeps of steps around several bases
    foreach (bases[b]) begin
      for (int d = -20; d <= 20; d++) begin
        send(bases[b], "R6");
        send(bases[b] + W'(d), req_of(d));
      end
    end

    // R7 wrap: all-ones then zero is +1
    send(32'hFFFF_FFFF, "R6");
    send(32'h0000_0000, "R7");
    send(32'hFFFF_FFFF, "R5");

    // R3 straight-line run: no toggles
    for (int i = 0; i < 8; i++) send(32'h0040_0000 + W'(i), (i == 0) ? "R6" : "R3");

    // R10: idle cycle keeps bus, bus_valid low
    hold_bus = bus_data; hold_flag = bus_flag;
    @(posedge clk); #1;
    chk(bus_data == hold_bus && bus_flag == hold_flag && !bus_valid, "R10",
        {bus_flag, bus_data}, {hold_flag, hold_bus});

    // R9 back-pressure
    @(negedge clk); dec_ready = 1'b0;
    send(32'h0040_0008, "R3");
    hold_bus = bus_data; hold_flag = bus_flag; hold_dec = dec_addr;
    @(negedge clk); in_valid = 1'b1; in_addr = 32'h0040_0009;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(!in_ready, "R9", {32'b0, in_ready}, '0);
      @(posedge clk); #1;
      chk(bus_data == hold_bus && bus_flag == hold_flag && dec_valid && dec_addr == hold_dec,
          "R9", {bus_flag, bus_data}, {hold_flag, hold_bus});
      @(negedge clk);
    end
    dec_ready = 1'b1;
    @(posedge clk); #1;
    chk(bus_data == hold_bus && bus_flag && bus_valid, "R9",
        {bus_flag, bus_data}, {1'b1, hold_bus});
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    chk(dec_valid && dec_addr == 32'h0040_0009, "R9",
        {dec_valid, dec_addr}, {1'b1, 32'h0040_0009});
    m_prev = 32'h0040_0009;

    // R7 sign boundary: 7FFFFFFF to 80000000 is +1
    send(32'h7FFF_FFFF, "R6");
    send(32'h8000_0000, "R7");

    report();
  end
endmodule